// File: doc/BRIEF.md
# Nibble Bus Peripheral Register Bank

This block is the responder on a narrow handshake bus where a master moves one 4-bit nibble per phase. The master raises a ready strobe with a mode bit, a half bit, a direction bit and four data bits. The block then acts on the phase and acknowledges it by inverting a completion bit. A phase with mode 0 picks a register ID that stays in force. A phase with mode 1 moves one nibble of the selected 8-bit register, either into the block (write) or out onto the return data lines (read).

Behind the sixteen IDs sit these resources:
- a pair of shared address bytes;
- a colour byte split into foreground and background nibbles;
- two small receive FIFOs, for keyboard and serial, whose occupancy is shown on two status flags;
- a 256-byte buffer, read through a register whose address advances by itself.

Every committed write is also presented on a one-cycle device write port, so that external device models can act on it.

Top module: `nibble_bus_regs`

## Requirements
- R1: After reset, these outputs are all 0: the completion bit, the return nibble, both status flags, both address bytes, both colour nibbles and the device write strobe. The selected register ID is 0.
- R2: On a rising edge of the ready strobe with mode = 0, the four data bits become the selected register ID. That ID remains in use for all later data phases until the next select phase.
- R3: The completion bit inverts exactly once per phase, of any kind. It inverts three clock edges after the first edge that samples the ready strobe high. The return nibble of a read phase is valid one edge before that inversion.
- R4: For a write phase (mode = 1, direction = 1), a nibble sent with half = 0 is only staged. The byte {high nibble, staged low nibble} is committed when the half = 1 phase is taken. At that moment the device write strobe pulses for one cycle and carries the ID and the byte.
- R5: For a read phase (mode = 1, direction = 0), the return nibble carries bits 3:0 of the selected register's value when half = 0, and bits 7:4 when half = 1.
- R6: ID 2 holds address byte A and ID 3 holds address byte B. Both can be written and read back, and both are visible on output ports.
- R7: ID 14 returns the buffer byte at address A. After each half = 1 read of ID 14, address A increases by one, modulo 256. A half = 0 read changes nothing.
- R8: ID 0 returns the oldest keyboard FIFO byte and ID 7 returns the oldest serial FIFO byte. An entry is removed only by a half = 1 read. An empty FIFO reads as 0x00. Each status flag is 1 while its FIFO holds data.
- R9: Each FIFO holds 8 bytes. A push while the FIFO is full is dropped.
- R10: ID 4 is the colour byte. Bits 3:0 drive the foreground output and bits 7:4 drive the background output.
- R11: A read of any ID other than 0, 2, 3, 4, 7 or 14 returns 0x00.
- R12: Only a rising edge of the ready strobe starts a phase. Holding the strobe high causes no further toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_nib | input | 4 | Nibble from master (ID or data) |
| m_half | input | 1 | 0 = bits 3:0, 1 = bits 7:4 |
| m_mode | input | 1 | 0 = register select, 1 = data phase |
| m_dir | input | 1 | 0 = read, 1 = write |
| m_rdy | input | 1 | Ready strobe, asynchronous |
| s_nib | output | 4 | Return nibble for reads |
| s_done | output | 1 | Completion bit, inverts per phase |
| s_kbd_avail | output | 1 | Keyboard FIFO not empty |
| s_ser_avail | output | 1 | Serial FIFO not empty |
| kbd_push | input | 1 | Push strobe, keyboard FIFO |
| kbd_push_byte | input | 8 | Byte pushed to keyboard FIFO |
| ser_push | input | 1 | Push strobe, serial FIFO |
| ser_push_byte | input | 8 | Byte pushed to serial FIFO |
| mem_load | input | 1 | Buffer write strobe |
| mem_load_addr | input | 8 | Buffer write address |
| mem_load_byte | input | 8 | Buffer write data |
| dev_wr_valid | output | 1 | One-cycle committed write strobe |
| dev_wr_id | output | 4 | ID of committed write |
| dev_wr_byte | output | 8 | Byte of committed write |
| addr_lo | output | 8 | Address byte A (ID 2) |
| addr_hi | output | 8 | Address byte B (ID 3) |
| fg_color | output | 4 | Foreground colour |
| bg_color | output | 4 | Background colour |

## Verification
The ready strobe passes through two synchroniser flops and one edge flop, so the phase is taken on the second edge after it is driven. The return nibble, the commit, the FIFO pop, the address step and the write strobe all appear after the third edge. The completion bit inverts after the fourth edge. The bench drives the strobe on a falling edge. It samples on the falling edge after the third rising edge, where it expects the nibble and side effects but no toggle yet. It samples again one edge later, where it expects the toggle. Flags and FIFO effects of a push are checked one edge after the push.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 4;

    typedef logic [ID_W-1:0]   reg_id_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam reg_id_t ID_KBD   = 4'd0;
    localparam reg_id_t ID_ADR_A = 4'd2;
    localparam reg_id_t ID_ADR_B = 4'd3;
    localparam reg_id_t ID_COLOR = 4'd4;
    localparam reg_id_t ID_SER   = 4'd7;
    localparam reg_id_t ID_BUF   = 4'd14;

    typedef struct packed {
        reg_id_t id;
        nib_t    stage;
        nib_t    rd_nib;
        logic    done;
        logic    pend;
        byte_t   adr_a;
        byte_t   adr_b;
        byte_t   color;
        logic    wr_valid;
        reg_id_t wr_id;
        byte_t   wr_byte;
    } core_state_t;
endpackage

// File: rtl/nbb_edge.sv
module nbb_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/nbb_fifo.sv
module nbb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_ptr_t;

    fifo_ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        p_d     = p_q;
        do_push = push && (p_q.cnt != FULL_CNT);
        do_pop  = pop && (p_q.cnt != '0);
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wp] <= push_data;
    end

    assign head      = (p_q.cnt != '0) ? mem_q[p_q.rp] : '0;
    assign not_empty = (p_q.cnt != '0);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= FULL_CNT);
    a_r9_full_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt == FULL_CNT && push && !pop) |=> (p_q.cnt == FULL_CNT));
endmodule

// File: rtl/nbb_bufmem.sv
module nbb_bufmem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nibble_bus_regs.sv
module nibble_bus_regs
    import nbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 8,
    parameter int BUF_AW      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] m_nib,
    input  logic       m_half,
    input  logic       m_mode,
    input  logic       m_dir,
    input  logic       m_rdy,
    output logic [3:0] s_nib,
    output logic       s_done,
    output logic       s_kbd_avail,
    output logic       s_ser_avail,
    input  logic       kbd_push,
    input  logic [7:0] kbd_push_byte,
    input  logic       ser_push,
    input  logic [7:0] ser_push_byte,
    input  logic       mem_load,
    input  logic [7:0] mem_load_addr,
    input  logic [7:0] mem_load_byte,
    output logic       dev_wr_valid,
    output logic [3:0] dev_wr_id,
    output logic [7:0] dev_wr_byte,
    output logic [7:0] addr_lo,
    output logic [7:0] addr_hi,
    output logic [3:0] fg_color,
    output logic [3:0] bg_color
);
    core_state_t s_d, s_q;
    logic  rise;
    logic  kbd_pop, ser_pop, kbd_ne, ser_ne;
    byte_t kbd_head, ser_head, buf_byte, rd_byte, wr_full;

    nbb_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(m_rdy), .rise(rise)
    );

    nbb_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_kbd (
        .clk(clk), .rst_n(rst_n), .push(kbd_push), .push_data(kbd_push_byte),
        .pop(kbd_pop), .head(kbd_head), .not_empty(kbd_ne)
    );

    nbb_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_ser (
        .clk(clk), .rst_n(rst_n), .push(ser_push), .push_data(ser_push_byte),
        .pop(ser_pop), .head(ser_head), .not_empty(ser_ne)
    );

    nbb_bufmem #(.AW(BUF_AW), .DW(BYTE_W)) u_buf (
        .clk(clk), .we(mem_load), .waddr(mem_load_addr[BUF_AW-1:0]),
        .wdata(mem_load_byte), .raddr(s_q.adr_a[BUF_AW-1:0]), .rdata(buf_byte)
    );

    always_comb begin
        case (s_q.id)
            ID_KBD:   rd_byte = kbd_head;
            ID_ADR_A: rd_byte = s_q.adr_a;
            ID_ADR_B: rd_byte = s_q.adr_b;
            ID_COLOR: rd_byte = s_q.color;
            ID_SER:   rd_byte = ser_head;
            ID_BUF:   rd_byte = buf_byte;
            default:  rd_byte = '0;
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.wr_valid = 1'b0;
        s_d.pend     = 1'b0;
        kbd_pop      = 1'b0;
        ser_pop      = 1'b0;
        wr_full      = {m_nib, s_q.stage};
        if (s_q.pend) s_d.done = ~s_q.done;
        if (rise) begin
            s_d.pend = 1'b1;
            if (!m_mode) begin
                s_d.id = m_nib;
            end else if (m_dir) begin
                if (!m_half) begin
                    s_d.stage = m_nib;
                end else begin
                    s_d.wr_valid = 1'b1;
                    s_d.wr_id    = s_q.id;
                    s_d.wr_byte  = wr_full;
                    case (s_q.id)
                        ID_ADR_A: s_d.adr_a = wr_full;
                        ID_ADR_B: s_d.adr_b = wr_full;
                        ID_COLOR: s_d.color = wr_full;
                        default:  ;
                    endcase
                end
            end else begin
                s_d.rd_nib = m_half ? rd_byte[7:4] : rd_byte[3:0];
                if (m_half) begin
                    case (s_q.id)
                        ID_KBD:  kbd_pop = kbd_ne;
                        ID_SER:  ser_pop = ser_ne;
                        ID_BUF:  s_d.adr_a = s_q.adr_a + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign s_nib        = s_q.rd_nib;
    assign s_done       = s_q.done;
    assign s_kbd_avail  = kbd_ne;
    assign s_ser_avail  = ser_ne;
    assign dev_wr_valid = s_q.wr_valid;
    assign dev_wr_id    = s_q.wr_id;
    assign dev_wr_byte  = s_q.wr_byte;
    assign addr_lo      = s_q.adr_a;
    assign addr_hi      = s_q.adr_b;
    assign fg_color     = s_q.color[3:0];
    assign bg_color     = s_q.color[7:4];

    a_r3_toggle_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |=> (s_done != $past(s_done)));
    a_r3_quiet_without_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend |=> $stable(s_done));
    a_r7_low_read_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && m_mode && !m_dir && !m_half) |=> $stable(addr_lo));
    a_r4_commit_on_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_wr_valid) |-> $past(rise && m_mode && m_dir && m_half));
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_valid |=> !dev_wr_valid);
endmodule

// File: tb/nibble_bus_regs_bench.sv
module nibble_bus_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] m_nib = '0;
    logic m_half = 0, m_mode = 0, m_dir = 0, m_rdy = 0;
    logic [3:0] s_nib;
    logic s_done, s_kbd_avail, s_ser_avail;
    logic kbd_push = 0, ser_push = 0, mem_load = 0;
    logic [7:0] kbd_push_byte = '0, ser_push_byte = '0;
    logic [7:0] mem_load_addr = '0, mem_load_byte = '0;
    logic dev_wr_valid;
    logic [3:0] dev_wr_id;
    logic [7:0] dev_wr_byte, addr_lo, addr_hi;
    logic [3:0] fg_color, bg_color;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic exp_done = 0;
    logic seen_wr_valid;
    logic [3:0] seen_wr_id;
    logic [7:0] seen_wr_byte;

    always #2.5 clk = ~clk;

    nibble_bus_regs u_nibble_bus_regs (
        .clk(clk), .rst_n(rst_n), .m_nib(m_nib), .m_half(m_half), .m_mode(m_mode),
        .m_dir(m_dir), .m_rdy(m_rdy), .s_nib(s_nib), .s_done(s_done),
        .s_kbd_avail(s_kbd_avail), .s_ser_avail(s_ser_avail),
        .kbd_push(kbd_push), .kbd_push_byte(kbd_push_byte),
        .ser_push(ser_push), .ser_push_byte(ser_push_byte),
        .mem_load(mem_load), .mem_load_addr(mem_load_addr), .mem_load_byte(mem_load_byte),
        .dev_wr_valid(dev_wr_valid), .dev_wr_id(dev_wr_id), .dev_wr_byte(dev_wr_byte),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .fg_color(fg_color), .bg_color(bg_color)
    );

    function automatic logic [7:0] buf_pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One bus phase; returns the nibble seen one edge before the toggle.
    task automatic phase(input logic mode, input logic dir, input logic half,
                         input logic [3:0] nib, input int hold, output logic [3:0] got);
        @(negedge clk);
        m_mode = mode; m_dir = dir; m_half = half; m_nib = nib; m_rdy = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        got = s_nib;
        seen_wr_valid = dev_wr_valid; seen_wr_id = dev_wr_id; seen_wr_byte = dev_wr_byte;
        chk(s_done == exp_done, "R3 no early toggle", s_done, exp_done);
        @(negedge clk);
        chk(s_done == ~exp_done, "R3 toggle per phase", s_done, ~exp_done);
        exp_done = ~exp_done;
        repeat (hold) @(negedge clk);
        if (hold > 0) chk(s_done == exp_done, "R12 held strobe no retoggle", s_done, exp_done);
        m_rdy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sel(input logic [3:0] id);
        logic [3:0] g;
        phase(1'b0, 1'b1, 1'b0, id, 0, g);
    endtask

    task automatic wr(input logic [7:0] b);
        logic [3:0] g;
        phase(1'b1, 1'b1, 1'b0, b[3:0], 0, g);
        chk(!seen_wr_valid, "R4 no commit on low nibble", seen_wr_valid, 0);
        phase(1'b1, 1'b1, 1'b1, b[7:4], 0, g);
    endtask

    task automatic rd(output logic [7:0] b);
        logic [3:0] lo, hi;
        phase(1'b1, 1'b0, 1'b0, 4'h0, 0, lo);
        phase(1'b1, 1'b0, 1'b1, 4'h0, 0, hi);
        b = {hi, lo};
    endtask

    task automatic push_kbd(input logic [7:0] b);
        @(negedge clk); kbd_push = 1; kbd_push_byte = b;
        @(negedge clk); kbd_push = 0;
    endtask

    task automatic push_ser(input logic [7:0] b);
        @(negedge clk); ser_push = 1; ser_push_byte = b;
        @(negedge clk); ser_push = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        report();
    end

    initial begin
        logic [7:0] b, prev;
        logic [3:0] g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(s_done == 0, "R1 done", s_done, 0);
        chk(s_nib == 0, "R1 nibble", s_nib, 0);
        chk(!s_kbd_avail && !s_ser_avail, "R1 flags", {s_kbd_avail, s_ser_avail}, 0);
        chk(addr_lo == 0 && addr_hi == 0, "R1 address", {addr_hi, addr_lo}, 0);
        chk(fg_color == 0 && bg_color == 0, "R1 colour", {bg_color, fg_color}, 0);
        chk(dev_wr_valid == 0, "R1 write strobe", dev_wr_valid, 0);

        // R11 unmapped IDs read zero; R8 empty FIFOs read zero
        for (int id = 0; id < 16; id++) begin
            if (id == 2 || id == 3 || id == 4 || id == 14) continue;
            sel(4'(id));
            rd(b);
            chk(b == 8'h00, (id == 0 || id == 7) ? "R8 empty reads zero" : "R11 unmapped reads zero", b, 0);
        end

        // R2 sticky select, R4 commit, R5 read halves, R10 colour fields
        sel(4'd4);
        prev = 8'h00;
        for (int v = 0; v < 256; v++) begin
            phase(1'b1, 1'b1, 1'b0, 4'(v), 0, g);
            chk({bg_color, fg_color} == prev, "R4 staged low nibble not committed", {bg_color, fg_color}, prev);
            phase(1'b1, 1'b1, 1'b1, 4'(v >> 4), 0, g);
            chk(seen_wr_valid && seen_wr_id == 4 && seen_wr_byte == 8'(v), "R4 device write port",
                {seen_wr_valid, seen_wr_id, seen_wr_byte}, {1'b1, 4'd4, 8'(v)});
            chk(fg_color == 4'(v) && bg_color == 4'(v >> 4), "R10 colour nibbles", {bg_color, fg_color}, v);
            rd(b);
            chk(b == 8'(v), "R5 read back both halves (R2 ID kept)", b, v);
            prev = 8'(v);
        end

        // R6 address bytes
        sel(4'd2); wr(8'hA5);
        sel(4'd3); wr(8'h3C);
        chk(addr_lo == 8'hA5 && addr_hi == 8'h3C, "R6 address outputs", {addr_hi, addr_lo}, 16'h3CA5);
        sel(4'd2); rd(b); chk(b == 8'hA5, "R6 read A", b, 8'hA5);
        sel(4'd3); rd(b); chk(b == 8'h3C, "R6 read B", b, 8'h3C);

        // R7 buffer register with auto-increment
        for (int a = 0; a < 256; a++) begin
            @(negedge clk); mem_load = 1; mem_load_addr = 8'(a); mem_load_byte = buf_pat(a);
        end
        @(negedge clk); mem_load = 0;
        sel(4'd2); wr(8'd250);
        sel(4'd14);
        phase(1'b1, 1'b0, 1'b0, 4'h0, 0, g);
        chk(g == buf_pat(250)[3:0], "R7 low nibble", g, buf_pat(250)[3:0]);
        chk(addr_lo == 8'd250, "R7 low read leaves address", addr_lo, 250);
        for (int i = 0; i < 12; i++) begin
            rd(b);
            chk(b == buf_pat((250 + i) % 256), "R7 buffer byte", b, buf_pat((250 + i) % 256));
            chk(addr_lo == 8'((251 + i) % 256), "R7 address step and wrap", addr_lo, (251 + i) % 256);
        end
        sel(4'd2); wr(8'd0); sel(4'd14);
        for (int a = 0; a < 256; a++) begin
            rd(b);
            chk(b == buf_pat(a), "R7 sequential sweep", b, buf_pat(a));
        end
        chk(addr_lo == 8'd0, "R7 full wrap", addr_lo, 0);

        // R8 / R9 keyboard FIFO
        for (int k = 0; k < 10; k++) push_kbd(8'(k * 13 + 5));
        chk(s_kbd_avail == 1, "R8 keyboard flag set", s_kbd_avail, 1);
        sel(4'd0);
        for (int k = 0; k < 8; k++) begin
            rd(b);
            chk(b == 8'(k * 13 + 5), "R9 FIFO order, overflow dropped", b, 8'(k * 13 + 5));
        end
        chk(s_kbd_avail == 0, "R9 only eight kept", s_kbd_avail, 0);
        rd(b);
        chk(b == 8'h00, "R8 empty after drain", b, 0);

        // R8 serial FIFO, low reads have no side effect
        push_ser(8'h9E); push_ser(8'h41);
        chk(s_ser_avail == 1, "R8 serial flag set", s_ser_avail, 1);
        sel(4'd7);
        phase(1'b1, 1'b0, 1'b0, 4'h0, 0, g);
        phase(1'b1, 1'b0, 1'b0, 4'h0, 0, g);
        rd(b); chk(b == 8'h9E, "R8 low reads do not pop", b, 8'h9E);
        rd(b); chk(b == 8'h41, "R8 second serial byte", b, 8'h41);
        chk(s_ser_avail == 0, "R8 serial flag clear", s_ser_avail, 0);

        // R12 strobe held high
        sel(4'd4);
        phase(1'b1, 1'b0, 1'b1, 4'h0, 8, g);
        chk(g == 4'hF, "R12 held read still correct", g, 4'hF);

        report();
    end
endmodule